// File: doc/BRIEF.md
# Serial Control Register Port

This block gives a device a three-wire serial programming port made of an enable line, a data line and a serial clock. A bank of eight 12-bit control registers sits behind the port. Other logic on the chip reads the full contents of the bank in parallel from a flat output bus. An external controller holds the enable line low and clocks a word in, most significant data bit first. Each rising edge of the serial clock shifts one bit into a 16-bit shift register. When enable rises, the block decodes the bits that were shifted in last, and the contents of the shift register take effect only at that moment.

A write word has 16 bits: twelve data bits, then three address bits, then a direction bit of 0. A read word has only four bits: the address, then a direction bit of 1. After a read is decoded, the block shifts the twelve bits of the addressed register out on a separate output pin. It sends one bit on each falling edge of the serial clock while enable stays high.

The three serial inputs arrive through two-flop synchronizers. The block detects their edges in the system clock domain. The serial clock therefore has to be much slower than the system clock. The port does not depend on anything else in the device and can be used at any time. The serial pins are a fixed bit-level protocol, so the port has no valid/ready flow control and no back-pressure. Nothing stalls the controller.

Top module: `srp_top`

## Requirements
- R1: Each rising edge of the synchronized serial clock shifts the synchronized data level into bit 0 of the 16-bit shift register, and the older bits move up by one.
- R2: The register bank changes only on the rising edge of the enable line. Serial clocking with enable held high leaves every register unchanged.
- R3: At a commit, shift register bit 0 selects the direction (0 = write, 1 = read), bits 3:1 hold the register address, and bits 15:4 hold the data. On the wire the data goes first (D11 down to D0), then A2, A1 and A0, and the direction bit goes last.
- R4: A write commit loads the 12 data bits into the addressed register and leaves the other seven registers unchanged.
- R5: If more than 16 bits are shifted in before a commit, only the last 16 count. Any extra leading bits have no effect.
- R6: A read needs only four serial bits. A read commit changes no register.
- R7: After a read commit, the falling edges of the serial clock that occur while enable is high drive the addressed register onto the readout pin, most significant bit first, one bit per edge, for twelve edges.
- R8: The readout pin is low at all times outside a twelve-bit readout. This includes after a write and on the falling edge that follows the twelfth bit.
- R9: Reset clears all eight registers to zero and drives the readout pin low.
- R10: The parallel output places register i at bits [12*i+11 : 12*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_en_i | input | 1 | Serial enable. Its rising edge commits the word |
| ser_dat_i | input | 1 | Serial data, sampled on a rising serial clock edge |
| rd_dat_o | output | 1 | Readout pin, changes on falling serial clock edges |
| regs_o | output | 96 | All eight registers, register i at [12*i +: 12] |

## Verification
The assertions assume that every serial level is held for at least three system clock cycles, so that each edge the synchronizers see is a real edge. They also assume that data is steady around the serial clock rise and that enable changes only while the serial clock is low. The bench drives all three serial pins on falling system clock edges and holds each level for six system cycles. Data and enable change only while the serial clock is low. The checks of the readout pin are taken late in the low phase, after the synchronized falling edge has taken effect.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {
    SRP_WRITE = 1'b0,
    SRP_READ  = 1'b1
  } srp_dir_e;

  // positions of the serial inputs inside the synchronizer vector
  localparam int SRP_SCLK = 0;
  localparam int SRP_SEN  = 1;
  localparam int SRP_SDAT = 2;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int N_SIG  = 3,
  parameter int N_EDGE = 2   // the low N_EDGE inputs also get a delayed copy
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SIG-1:0]  async_i,
  output logic [N_SIG-1:0]  lvl_o,
  output logic [N_EDGE-1:0] dly_o
);
  logic [N_SIG-1:0] meta_q;

  for (genvar i = 0; i < N_SIG; i++) begin : g_sig
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        lvl_o[i]  <= 1'b0;
      end else begin
        meta_q[i] <= async_i[i];
        lvl_o[i]  <= meta_q[i];
      end
    end
    if (i < N_EDGE) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_o[i] <= 1'b0;
        else        dly_o[i] <= lvl_o[i];
      end
    end
  end
endmodule

// File: rtl/srp_shift.sv
module srp_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_o <= '0;
    else if (shift_en) word_o <= {word_o[WORD_W-2:0], din};
  end
endmodule

// File: rtl/srp_bank.sv
module srp_bank #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  localparam int N_REG = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic [N_REG*DATA_W-1:0] flat_o
);
  logic [DATA_W-1:0] regs_q [N_REG];

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 regs_q[i] <= '0;
      else if (we && addr == ADDR_W'(i))          regs_q[i] <= wdata;
    end
    assign flat_o[i*DATA_W +: DATA_W] = regs_q[i];
  end

  assign rdata = regs_q[addr];
endmodule

// File: rtl/srp_readout.sv
module srp_readout #(
  parameter int DATA_W = 12,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              step,
  output logic              sdo_o,
  output logic [CNT_W-1:0]  left_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_o <= '0;
      sdo_o  <= 1'b0;
    end else if (load) begin
      sh_q   <= load_data;
      left_o <= CNT_W'(DATA_W);
    end else if (step) begin
      if (left_o != '0) begin
        sdo_o  <= sh_q[DATA_W-1];
        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
        left_o <= left_o - 1'b1;
      end else begin
        sdo_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srp_top.sv
module srp_top #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 3,
  localparam int N_REG  = 1 << ADDR_W,
  localparam int WORD_W = DATA_W + ADDR_W + 1,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk_i,
  input  logic                    ser_en_i,
  input  logic                    ser_dat_i,
  output logic                    rd_dat_o,
  output logic [N_REG*DATA_W-1:0] regs_o
);
  import srp_pkg::*;

  logic [2:0]        lvl;
  logic [1:0]        dly;
  logic              sclk_rise, sclk_fall, sen_rise, rd_step;
  logic [WORD_W-1:0] word;
  srp_dir_e          dir;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              do_write, do_read;
  logic [CNT_W-1:0]  rd_left;

  srp_sync #(.N_SIG(3), .N_EDGE(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_dat_i, ser_en_i, ser_clk_i}),
    .lvl_o(lvl), .dly_o(dly)
  );

  assign sclk_rise = lvl[SRP_SCLK] & ~dly[SRP_SCLK];
  assign sclk_fall = ~lvl[SRP_SCLK] & dly[SRP_SCLK];
  assign sen_rise  = lvl[SRP_SEN] & ~dly[SRP_SEN];
  assign rd_step   = sclk_fall & lvl[SRP_SEN];

  srp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .din(lvl[SRP_SDAT]), .word_o(word)
  );

  // word layout: [0] direction, [ADDR_W:1] address, [WORD_W-1:ADDR_W+1] data
  assign dir      = srp_dir_e'(word[0]);
  assign addr     = word[ADDR_W:1];
  assign wdata    = word[WORD_W-1:ADDR_W+1];
  assign do_write = sen_rise && dir == SRP_WRITE;
  assign do_read  = sen_rise && dir == SRP_READ;

  srp_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(do_write), .addr(addr), .wdata(wdata),
    .rdata(rdata), .flat_o(regs_o)
  );

  srp_readout #(.DATA_W(DATA_W)) u_readout (
    .clk(clk), .rst_n(rst_n),
    .load(do_read), .load_data(rdata), .step(rd_step),
    .sdo_o(rd_dat_o), .left_o(rd_left)
  );
endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int DATA_W = 12,
  parameter int N_REG  = 8,
  parameter int CNT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sen_rise,
  input logic                    do_read,
  input logic                    rd_step,
  input logic [CNT_W-1:0]        rd_left,
  input logic                    rd_dat_o,
  input logic [N_REG*DATA_W-1:0] regs_o
);
  logic [N_REG*DATA_W-1:0] prev_q;
  logic [N_REG-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= regs_o;
  end

  for (genvar i = 0; i < N_REG; i++) begin : g_chg
    assign chg[i] = regs_o[i*DATA_W +: DATA_W] != prev_q[i*DATA_W +: DATA_W];
  end

  // R2: the bank moves only in the cycle after an enable rise
  a_r2_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_rise |=> $stable(regs_o));

  // R4: a commit changes at most one register
  a_r4_one_reg: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  // R6: a read commit leaves the bank untouched
  a_r6_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    do_read |=> $stable(regs_o));

  // R7: the readout pin changes only on a step
  a_r7_pin_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_step |=> $stable(rd_dat_o));

  // R7: at most twelve bits pending
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_left <= CNT_W'(DATA_W));

  // R8: an idle step drives the pin low
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && rd_left == '0 && !do_read) |=> !rd_dat_o);
endmodule

bind srp_top srp_checker #(.DATA_W(DATA_W), .N_REG(N_REG), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_rise(sen_rise), .do_read(do_read),
  .rd_step(rd_step), .rd_left(rd_left), .rd_dat_o(rd_dat_o), .regs_o(regs_o)
);

// File: tb/srp_top_bench.sv
module srp_top_bench;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sen = 1'b0, sdat = 1'b0;
  logic        rd_dat;
  logic [95:0] regs;
  logic [11:0] exp_reg [8];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  srp_top u_srp_top (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_en_i(sen),
    .ser_dat_i(sdat), .rd_dat_o(rd_dat), .regs_o(regs)
  );

  task automatic hold();
    repeat (H) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send the low n bits of w, most significant of them first
  task automatic shift_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i]; hold();
      sclk = 1'b1; hold();
      sclk = 1'b0; hold();
    end
  endtask

  task automatic begin_xfer();
    sen = 1'b0; hold();
  endtask

  task automatic commit();
    sen = 1'b1; hold(); hold();
  endtask

  task automatic check_bank(string req);
    for (int a = 0; a < 8; a++) check(req, 32'(regs[a*12 +: 12]), 32'(exp_reg[a]));
  endtask

  task automatic write_reg(logic [2:0] a, logic [11:0] d);
    begin_xfer();
    shift_bits({16'h0, d, a, 1'b0}, 16);   // R3 layout: data, address, direction 0
    commit();
    exp_reg[a] = d;
  endtask

  task automatic read_reg(logic [2:0] a, output logic [11:0] got);
    begin_xfer();
    shift_bits({28'h0, a, 1'b1}, 4);
    commit();
    got = '0;
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b1; hold();
      sclk = 1'b0; hold();
      got = {got[10:0], rd_dat};
    end
  endtask

  task automatic t_reset();
    check_bank("R9");
    check("R9 rd_dat", 32'(rd_dat), 0);
  endtask

  task automatic t_write_read();
    logic [11:0] got;
    write_reg(3'd0, 12'hA5C);
    write_reg(3'd7, 12'h3E1);
    write_reg(3'd4, 12'h801);
    check_bank("R4 R10");
    check("R8 low after write", 32'(rd_dat), 0);
    read_reg(3'd7, got);
    check("R7 R1 read reg7", 32'(got), 32'(exp_reg[7]));
    sclk = 1'b1; hold(); sclk = 1'b0; hold();
    check("R8 low after twelfth bit", 32'(rd_dat), 0);
    read_reg(3'd4, got);
    check("R7 read reg4", 32'(got), 32'h801);
    read_reg(3'd2, got);
    check("R7 read empty reg2", 32'(got), 0);
  endtask

  task automatic t_long_word();
    begin_xfer();
    // four leading bits (1011) precede a write of 0x6C3 to register 5
    shift_bits({12'h0, 4'hB, 12'h6C3, 3'd5, 1'b0}, 20);
    commit();
    exp_reg[5] = 12'h6C3;
    check_bank("R5 R3");
  endtask

  task automatic t_short_read();
    logic [11:0] got;
    begin_xfer();
    // a full write-length prefix, then a 4-bit read of register 0
    shift_bits({16'h0, 12'hFFF, 3'd1, 1'b0}, 16);
    shift_bits({28'h0, 3'd0, 1'b1}, 4);
    commit();
    check_bank("R6 no register changed");
    got = '0;
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b1; hold(); sclk = 1'b0; hold();
      got = {got[10:0], rd_dat};
    end
    check("R6 R7 short read reg0", 32'(got), 32'hA5C);
  endtask

  task automatic t_no_commit();
    // enable already high from the last transfer: shifting must not commit
    shift_bits({16'h0, 12'h123, 3'd6, 1'b0}, 16);
    check_bank("R2 no enable rise");
    sen = 1'b0; hold();
    check_bank("R2 enable fall");
  endtask

  initial begin
    for (int a = 0; a < 8; a++) exp_reg[a] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    hold();
    t_write_read();
    t_long_word();
    t_short_read();
    t_no_commit();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule